// File: doc/BRIEF.md
# Event Timestamp Capture with Gate Arbitration

This block keeps a free-running 32-bit tag counter that advances on a tick of selectable rate. It watches four gate lines. The first rising edge on any enabled gate freezes the current counter value in a holding register. It also records a 2-bit code naming the gate that fired and raises an event-pending flag. While the flag is up, all further gate edges are ignored.

The flag drops when one of two things happens. The first is an external clear, which the surrounding readout logic gives once the event has been collected. The second is an internal timeout, which runs from the moment of capture. The timeout length is an 8-bit step count, and a count of zero turns the timeout off. When the timeout fires, the block emits a one-cycle pulse. If a readout request arrives first, the timeout stops and the event stays pending until the external clear.

The first two gate lines can each come from either a front-panel input or a master gate line, as chosen by a select bit. Each gate passes through a synchronizer and a rising-edge detector before arbitration.

Top module: `event_stamp_capture`

## Requirements
- R1: Gate a is `masterGateA` when `srcSelA`=1 and `nimGate[0]` when it is 0. Gate b is `masterGateB` when `srcSelB`=1 and `nimGate[1]` when it is 0. Gates c and d are always `nimGate[2]` and `nimGate[3]`. A deselected line has no effect.
- R2: Gates are ranked a > b > c > d. The source code is 0 for a, 1 for b, 2 for c and 3 for d. If several gates rise in the same cycle, the code of the highest-ranked one is recorded.
- R3: A rising gate line is synchronized through two flops. Its capture shows on `eventPending`, `heldSrc` and `heldTag` three clock edges after the line changes. `heldTag` equals the counter value present just before the capture edge.
- R4: While `eventPending` is 1, further gate edges change neither `heldTag` nor `heldSrc`.
- R5: `armClear` drops `eventPending` on the next edge. A later gate edge is then captured again.
- R6: With `timeoutSteps`=N>0 and no readout request, `eventPending` drops and `timeoutPulse` is high for exactly one cycle, N×TO_DIV edges after the capture edge.
- R7: With `timeoutSteps`=0, an event stays pending indefinitely and no timeout pulse occurs.
- R8: A `readReq` while the timeout runs stops it. The event then stays pending with no pulse until `armClear`.
- R9: The counter advances once per BASE_DIV×10^k clocks, where k is `divSel` read as a number. `divSel[0]` is divider bit A and `divSel[1]` is bit B, so A alone selects the 10× slower rate and B alone the 100× slower rate.
- R10: Reset and `fastClear` set the counter and its prescaler to zero. After reset, all outputs are zero.
- R11: While `runEn` is 0, gate edges are not accepted.
- R12: Only rising edges count. A gate held high across a re-arm does not cause a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nimGate | input | 4 | Front-panel gate lines, index 0 to 3 |
| masterGateA | input | 1 | Alternative source for gate a |
| masterGateB | input | 1 | Alternative source for gate b |
| srcSelA | input | 1 | 1 selects masterGateA for gate a |
| srcSelB | input | 1 | 1 selects masterGateB for gate b |
| runEn | input | 1 | Gate acceptance enable |
| armClear | input | 1 | External re-arm clear |
| readReq | input | 1 | Readout request; stops the timeout |
| fastClear | input | 1 | Clears the tag counter |
| divSel | input | 2 | Tick rate select, bit 0 = A, bit 1 = B |
| timeoutSteps | input | TO_W | Timeout length in steps, 0 = off |
| heldTag | output | TAG_W | Counter value frozen at capture |
| heldSrc | output | 2 | Code of the gate that was captured |
| eventPending | output | 1 | Event captured and gates locked |
| timeoutPulse | output | 1 | One-cycle pulse on timeout expiry |

## Verification
Each result has a fixed due time:
- A capture is due three edges after the gate line changes.
- A re-arm is due one edge after `armClear`.
- A timeout is due N×TO_DIV edges after the capture edge.
- The held tag is the clock-edge distance from the last counter clear, integer-divided by the selected period.

The bench counts clock edges and records the edge of every clear and gate drive. It computes the due edge and the expected values of each result and queues them. The monitor compares the outputs only on the falling edge that follows the due edge, and it reports any queued item that was left past its due edge.

// File: rtl/esc_pkg.sv
package esc_pkg;

  localparam int GATES = 4;
  localparam int SRC_W = 2;

  typedef struct packed {
    logic             capture;
    logic [SRC_W-1:0] srcCode;
  } esc_strobe_t;

  function automatic int unsigned decadeFactor(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 10;
      2'd2:    return 100;
      default: return 1000;
    endcase
  endfunction

endpackage

// File: rtl/esc_gate_sync.sv
module esc_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateIn,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], gateIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int TO_DIV = 20,
  parameter int TO_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GATES-1:0] rise,
  input  logic             runEn,
  input  logic             armClear,
  input  logic             readReq,
  input  logic [TO_W-1:0]  timeoutSteps,
  output esc_strobe_t      strobe,
  output logic             eventPending,
  output logic [SRC_W-1:0] heldSrc,
  output logic             timeoutPulse
);
  localparam int PRE_W = (TO_DIV > 1) ? $clog2(TO_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TO_DIV - 1);

  logic [SRC_W-1:0] winCode;
  logic             accept;
  logic             toActive;
  logic [PRE_W-1:0] stepPre;
  logic [TO_W-1:0]  stepCnt;
  logic [TO_W:0]    nextCnt;
  logic             stepTick;
  logic             expire;

  // fixed priority: lowest index wins
  always_comb begin
    winCode = '0;
    for (int i = GATES - 1; i >= 0; i--) begin
      if (rise[i]) winCode = SRC_W'(i);
    end
  end

  assign accept   = (|rise) & runEn & ~eventPending & ~armClear;
  assign nextCnt  = {1'b0, stepCnt} + {{TO_W{1'b0}}, 1'b1};
  assign stepTick = toActive && (stepPre == PRE_LAST);
  assign expire   = stepTick && (nextCnt == {1'b0, timeoutSteps});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventPending <= 1'b0;
      heldSrc      <= '0;
      toActive     <= 1'b0;
      stepPre      <= '0;
      stepCnt      <= '0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
      if (armClear) begin
        eventPending <= 1'b0;
        toActive     <= 1'b0;
      end else if (accept) begin
        eventPending <= 1'b1;
        heldSrc      <= winCode;
        toActive     <= (timeoutSteps != '0);
        stepPre      <= '0;
        stepCnt      <= '0;
      end else if (toActive) begin
        if (readReq) begin
          toActive <= 1'b0;
        end else if (stepTick) begin
          stepPre <= '0;
          if (expire) begin
            timeoutPulse <= 1'b1;
            eventPending <= 1'b0;
            toActive     <= 1'b0;
          end else begin
            stepCnt <= nextCnt[TO_W-1:0];
          end
        end else begin
          stepPre <= stepPre + PRE_W'(1);
        end
      end
    end
  end

  assign strobe.capture = accept;
  assign strobe.srcCode = winCode;

  assert_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventPending) |->
      ((($past(rise) >> heldSrc) & GATES'(1)) != '0) &&
      (($past(rise) & ((GATES'(1) << heldSrc) - GATES'(1))) == '0));

  assert_lockout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (eventPending && !armClear) |=> $stable(heldSrc));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_pulse_rearm_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !eventPending);

  assert_zero_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> ($past(timeoutSteps) != '0));

  assert_run_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !eventPending) |=> !eventPending);
endmodule

// File: rtl/esc_datapath.sv
module esc_datapath
  import esc_pkg::*;
#(
  parameter int TAG_W    = 32,
  parameter int BASE_DIV = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastClear,
  input  logic [1:0]       divSel,
  input  esc_strobe_t      strobe,
  output logic [TAG_W-1:0] heldTag
);
  localparam int MAX_PERIOD = BASE_DIV * 1000;
  localparam int PRE_W      = $clog2(MAX_PERIOD + 1);

  logic [PRE_W-1:0] period;
  logic [PRE_W-1:0] preCnt;
  logic [TAG_W-1:0] tagCount;
  logic             tick;

  always_comb period = PRE_W'(BASE_DIV * decadeFactor(divSel));

  assign tick = (preCnt >= (period - PRE_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      tagCount <= '0;
    end else if (fastClear) begin
      preCnt   <= '0;
      tagCount <= '0;
    end else if (tick) begin
      preCnt   <= '0;
      tagCount <= tagCount + TAG_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // the registered count is latched, so a capture never sees a partial update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldTag <= '0;
    else if (strobe.capture) heldTag <= tagCount;
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    fastClear |=> (tagCount == '0));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fastClear |=> ((tagCount == $past(tagCount)) ||
                    (tagCount == $past(tagCount) + TAG_W'(1))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(heldTag));
endmodule

// File: rtl/event_stamp_capture.sv
module event_stamp_capture
  import esc_pkg::*;
#(
  parameter int TAG_W       = 32,
  parameter int BASE_DIV    = 10,
  parameter int TO_DIV      = 20,
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       nimGate,
  input  logic             masterGateA,
  input  logic             masterGateB,
  input  logic             srcSelA,
  input  logic             srcSelB,
  input  logic             runEn,
  input  logic             armClear,
  input  logic             readReq,
  input  logic             fastClear,
  input  logic [1:0]       divSel,
  input  logic [TO_W-1:0]  timeoutSteps,
  output logic [TAG_W-1:0] heldTag,
  output logic [1:0]       heldSrc,
  output logic             eventPending,
  output logic             timeoutPulse
);
  logic [GATES-1:0] gateMux;
  logic [GATES-1:0] rise;
  esc_strobe_t      strobe;

  assign gateMux[0] = srcSelA ? masterGateA : nimGate[0];
  assign gateMux[1] = srcSelB ? masterGateB : nimGate[1];
  assign gateMux[2] = nimGate[2];
  assign gateMux[3] = nimGate[3];

  for (genvar g = 0; g < GATES; g++) begin : gSync
    esc_gate_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .gateIn (gateMux[g]),
      .rise   (rise[g])
    );
  end

  esc_ctrl #(.TO_DIV(TO_DIV), .TO_W(TO_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .rise         (rise),
    .runEn        (runEn),
    .armClear     (armClear),
    .readReq      (readReq),
    .timeoutSteps (timeoutSteps),
    .strobe       (strobe),
    .eventPending (eventPending),
    .heldSrc      (heldSrc),
    .timeoutPulse (timeoutPulse)
  );

  esc_datapath #(.TAG_W(TAG_W), .BASE_DIV(BASE_DIV)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .fastClear (fastClear),
    .divSel    (divSel),
    .strobe    (strobe),
    .heldTag   (heldTag)
  );
endmodule

// File: tb/tb_event_stamp_capture.sv
module tb_event_stamp_capture;
  localparam int TAG_W = 32;
  localparam int BASE_DIV = 10;
  localparam int TO_DIV = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] nimGate = '0;
  logic masterGateA = 1'b0, masterGateB = 1'b0;
  logic srcSelA = 1'b0, srcSelB = 1'b0;
  logic runEn = 1'b1, armClear = 1'b0, readReq = 1'b0, fastClear = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic [7:0] timeoutSteps = 8'd0;
  logic [TAG_W-1:0] heldTag;
  logic [1:0] heldSrc;
  logic eventPending, timeoutPulse;

  event_stamp_capture dut (
    .clk(clk), .rstN(rstN), .nimGate(nimGate), .masterGateA(masterGateA),
    .masterGateB(masterGateB), .srcSelA(srcSelA), .srcSelB(srcSelB),
    .runEn(runEn), .armClear(armClear), .readReq(readReq),
    .fastClear(fastClear), .divSel(divSel), .timeoutSteps(timeoutSteps),
    .heldTag(heldTag), .heldSrc(heldSrc), .eventPending(eventPending),
    .timeoutPulse(timeoutPulse)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int     due;
    string  req;
    int     pend;
    int     pulse;
    int     src;
    longint tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int clrEdge = 0;

  task automatic compareNow(input exp_t it);
    checks++;
    if (int'(eventPending) != it.pend || int'(timeoutPulse) != it.pulse ||
        (it.src >= 0 && int'(heldSrc) != it.src) ||
        (it.tag >= 0 && longint'(heldTag) != it.tag)) begin
      errors++;
      $display("FAIL %s edge %0d: got pend=%0d pulse=%0d src=%0d tag=%0d, expected pend=%0d pulse=%0d src=%0d tag=%0d",
               it.req, cyc, eventPending, timeoutPulse, heldSrc, heldTag,
               it.pend, it.pulse, it.src, it.tag);
    end
  endtask

  task automatic expectAt(input int due, input string req, input int pend,
                          input int pulse, input int src, input longint tag);
    exp_t it;
    it.due = due; it.req = req; it.pend = pend; it.pulse = pulse;
    it.src = src; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare each item on the falling edge after its due edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      if (it.due < cyc) begin
        checks++; errors++;
        $display("FAIL %s: item due at edge %0d, expected at %0d but seen at %0d",
                 it.req, it.due, it.due, cyc);
      end else compareNow(it);
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic longint expTag(input int g);
    int period;
    period = BASE_DIV;
    for (int k = 0; k < int'(divSel); k++) period = period * 10;
    return longint'((g + 3 - clrEdge - 1) / period);
  endfunction

  task automatic doFastClear();
    @(negedge clk); fastClear = 1'b1;
    @(negedge clk); fastClear = 1'b0; clrEdge = cyc;
  endtask

  task automatic fire(input logic [3:0] nim, input logic ma, input logic mb, output int g);
    @(negedge clk);
    nimGate = nim; masterGateA = ma; masterGateB = mb;
    g = cyc;
  endtask

  task automatic releaseGates();
    repeat (4) @(negedge clk);
    nimGate = '0; masterGateA = 1'b0; masterGateB = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rearm(input string req);
    @(negedge clk); armClear = 1'b1;
    expectAt(cyc + 1, req, 0, 0, -1, -1);
    @(negedge clk); armClear = 1'b0;
    drain();
  endtask

  initial begin : main
    int g;
    longint t;
    exp_t it;
    repeat (3) @(negedge clk);
    // R10: reset state
    it.due = 0; it.req = "R10 reset"; it.pend = 0; it.pulse = 0; it.src = 0; it.tag = 0;
    compareNow(it);
    rstN = 1'b1;

    // R3 R9: basic capture at base rate, gate c
    doFastClear();
    repeat (53) @(negedge clk);
    fire(4'b0100, 1'b0, 1'b0, g);
    t = expTag(g);
    expectAt(g + 2, "R3 not yet", 0, 0, 0, 0);
    expectAt(g + 3, "R3 capture", 1, 0, 2, t);
    releaseGates(); drain();

    // R4: lockout of a higher-priority gate
    fire(4'b0001, 1'b0, 1'b0, g);
    expectAt(g + 3, "R4 lockout", 1, 0, 2, t);
    expectAt(g + 10, "R4 lockout later", 1, 0, 2, t);
    releaseGates(); drain();

    // R7: zero timeout keeps the event pending
    expectAt(cyc + 300, "R7 no timeout", 1, 0, 2, t);
    drain();
    rearm("R5 arm clear");

    // R5: re-armed capture of gate d
    fire(4'b1000, 1'b0, 1'b0, g);
    expectAt(g + 3, "R5 recapture", 1, 0, 3, expTag(g));
    releaseGates(); drain();
    rearm("R5 arm clear 2");

    // R2: simultaneous b, c, d -> b
    fire(4'b1110, 1'b0, 1'b0, g);
    expectAt(g + 3, "R2 priority", 1, 0, 1, -1);
    releaseGates(); drain();
    rearm("R5 arm clear 3");

    // R1: selected master line for a; deselected front-panel line ignored
    srcSelA = 1'b1; srcSelB = 1'b1;
    fire(4'b0011, 1'b0, 1'b0, g);
    expectAt(g + 3, "R1 deselected ignored", 0, 0, -1, -1);
    expectAt(g + 5, "R1 deselected ignored later", 0, 0, -1, -1);
    releaseGates(); drain();
    fire(4'b1000, 1'b0, 1'b1, g);
    expectAt(g + 3, "R1 R2 master b beats d", 1, 0, 1, -1);
    releaseGates(); drain();
    rearm("R5 arm clear 4");
    fire(4'b0000, 1'b1, 1'b0, g);
    expectAt(g + 3, "R1 master a", 1, 0, 0, -1);
    releaseGates(); drain();
    rearm("R5 arm clear 5");
    srcSelA = 1'b0; srcSelB = 1'b0;

    // R6: timeout after 3 steps
    timeoutSteps = 8'd3;
    fire(4'b0010, 1'b0, 1'b0, g);
    expectAt(g + 3, "R6 capture", 1, 0, 1, -1);
    expectAt(g + 3 + 3*TO_DIV - 1, "R6 before expiry", 1, 0, 1, -1);
    expectAt(g + 3 + 3*TO_DIV, "R6 expiry pulse", 0, 1, 1, -1);
    expectAt(g + 3 + 3*TO_DIV + 1, "R6 pulse single", 0, 0, 1, -1);
    releaseGates(); drain();

    // R8: readout request stops the timeout
    fire(4'b0100, 1'b0, 1'b0, g);
    releaseGates();
    while (cyc < g + 13) @(negedge clk);
    readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
    expectAt(g + 3 + 3*TO_DIV, "R8 stopped", 1, 0, 2, -1);
    expectAt(g + 3 + 3*TO_DIV + 40, "R8 still pending", 1, 0, 2, -1);
    drain();
    rearm("R8 arm clear");
    timeoutSteps = 8'd0;

    // R9: slower tick rates
    for (int d = 1; d < 4; d++) begin
      divSel = 2'(d);
      doFastClear();
      repeat (25 * BASE_DIV) @(negedge clk);
      for (int k = 1; k < d; k++) repeat (9 * 25 * BASE_DIV * (k == 1 ? 1 : 10)) @(negedge clk);
      fire(4'b0100, 1'b0, 1'b0, g);
      expectAt(g + 3, "R9 divided rate", 1, 0, 2, expTag(g));
      releaseGates(); drain();
      rearm("R9 arm clear");
    end
    divSel = 2'b00;

    // R10: fast clear zeroes the counter
    repeat (40) @(negedge clk);
    doFastClear();
    fire(4'b1000, 1'b0, 1'b0, g);
    expectAt(g + 3, "R10 fast clear", 1, 0, 3, 0);
    releaseGates(); drain();
    rearm("R10 arm clear");

    // R11: run disabled
    runEn = 1'b0;
    fire(4'b0001, 1'b0, 1'b0, g);
    expectAt(g + 3, "R11 run off", 0, 0, -1, -1);
    expectAt(g + 6, "R11 run off later", 0, 0, -1, -1);
    releaseGates(); drain();
    runEn = 1'b1;

    // R12: level held across re-arm gives no new capture
    fire(4'b0001, 1'b0, 1'b0, g);
    expectAt(g + 3, "R12 first edge", 1, 0, 0, -1);
    drain();
    @(negedge clk); armClear = 1'b1;
    @(negedge clk); armClear = 1'b0;
    expectAt(cyc + 8, "R12 held level ignored", 0, 0, 0, -1);
    drain();
    nimGate = '0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule